// File: doc/BRIEF.md
# Single-to-Half Precision Narrowing Unit with Stochastic Rounding

This unit converts one IEEE 754 binary32 word per accepted transfer into an IEEE 754 binary16 word. Each request carries its own mode bit. With the bit clear, the result is rounded to nearest with ties to even. With the bit set, the result is rounded stochastically: it rounds up with a probability equal to the fraction of a unit in the last place that the narrowing throws away. Every conversion is rounded on its own, so a chain of narrowed partial sums stays unbiased on average.

The random numbers come from an internal xoroshiro128+ generator. The generator steps once for each accepted stochastic conversion and does not move otherwise. Software can reload its 128-bit state through a seed port. The result appears in a register one cycle after acceptance. Overflow saturates to a signed infinity, NaNs stay quiet NaNs, and values below the smallest half-precision normal are rounded into the subnormal range under the selected mode.

Top module: `fp16_narrow_sr`

## Requirements
- R1: While reset is asserted and after its release, `out_valid` is 0 and `out_data` is 16'h0000 until the first accepted conversion.
- R2: A conversion is accepted when `in_valid` and `in_ready` are both high at a rising edge. Its result shows in `out_data` with `out_valid` high after that same edge. `out_data` holds its value otherwise. `in_ready` is low in any cycle where `seed_load` is high, and a request presented in that cycle has no effect.
- R3: With `in_stoch` = 0, the result is the binary16 value nearest the input. A tie rounds to the candidate whose least significant stored bit is 0.
- R4: An input that binary16 represents exactly converts to that exact value in both modes. In stochastic mode, a conversion that discards only zero bits never rounds up.
- R5: With `in_stoch` = 0 the rounding rule is R3. With `in_stoch` = 1, let k be the number of discarded significand bits (13 for normal results, more for subnormal results). The result rounds up by one unit in the last place exactly when the top k bits of the generator output, read as an unsigned number, are less than the k discarded bits.
- R6: The generator state is two 64-bit words s0 and s1, and its output is s0+s1 mod 2^64. One step computes t = s0^s1, then s0 becomes rotl(s0,24)^t^(t<<16) and s1 becomes rotl(t,37). It steps only on an accepted conversion with `in_stoch` = 1, and that conversion uses the output from before the step.
- R7: Reset loads s0 = 64'h9E3779B97F4A7C15 and s1 = 64'hD1B54A32D192ED03. A `seed_load` cycle loads s0 = `seed_value[63:0]` and s1 = `seed_value[127:64]`. A zero seed loads the reset state instead, so the state is never all zero.
- R8: A finite input whose rounded magnitude is above 65504 gives signed infinity (magnitude 15'h7C00). An infinite input gives the infinity of the same sign. A finite input of magnitude at most 65504 never gives infinity.
- R9: A NaN input gives {sign, 5'b11111, 1'b1, input fraction bits 22..14}: a quiet NaN with the sign kept.
- R10: A result below 2^-14 in magnitude is rounded to a multiple of 2^-24 under the selected mode. Binary32 subnormal inputs round to zero in nearest mode.
- R11: The output sign bit always equals the input sign bit, including for zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A conversion request is present |
| in_ready | output | 1 | Request can be taken (low during a seed load) |
| in_data | input | 32 | Binary32 operand |
| in_stoch | input | 1 | 1 selects stochastic rounding, 0 selects nearest-even |
| seed_load | input | 1 | Load the generator state this cycle |
| seed_value | input | 128 | New generator state {s1, s0} |
| out_valid | output | 1 | `out_data` was updated at the last edge |
| out_data | output | 16 | Registered binary16 result |

## Verification
On every cycle, the assertions check the timing rules: one-cycle latency, a held output, a generator that stays still when it is not stepped, and a state that is never zero. On every conversion they also check sign preservation, quiet NaNs, exact results in both modes, and that no in-range value goes to infinity. Only the bench's reference model can show the rounding decisions themselves: ties to even, the comparison of the random slice against the discarded bits, subnormal rounding, and the exact sequence of generator steps across seed loads. It compares against that model on every clock, over directed corner values and a random sweep in both modes.

// File: rtl/fp16sr_pkg.sv
package fp16sr_pkg;
   localparam logic [14:0]  HALF_INF_MAG = 15'h7C00;
   localparam logic [4:0]   HALF_EXP_MAX = 5'h1F;
   localparam logic [127:0] DEFAULT_STATE = {64'hD1B54A32D192ED03, 64'h9E3779B97F4A7C15};

   function automatic logic [63:0] rotl64(input logic [63:0] v, input int unsigned k);
      return (v << k) | (v >> (64 - k));
   endfunction
endpackage

// File: rtl/fp16sr_xoro.sv
module fp16sr_xoro #(
   parameter logic [127:0] SEED_INIT = fp16sr_pkg::DEFAULT_STATE,
   parameter int unsigned  ROT_A     = 24,
   parameter int unsigned  SHL_B     = 16,
   parameter int unsigned  ROT_C     = 37
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         load,
   input  logic [127:0] seed,
   output logic [63:0]  rnd
);
   import fp16sr_pkg::*;

   if (SEED_INIT == 128'd0) begin : g_bad_seed
      $error("SEED_INIT must be nonzero");
   end
   if (ROT_A == 0 || ROT_A > 63 || ROT_C == 0 || ROT_C > 63 || SHL_B == 0 || SHL_B > 63) begin : g_bad_shift
      $error("generator shift amounts must lie in 1..63");
   end

   logic [63:0] s0_q, s1_q, mix, s0_n, s1_n;

   assign rnd  = s0_q + s1_q;
   assign mix  = s0_q ^ s1_q;
   assign s0_n = rotl64(s0_q, ROT_A) ^ mix ^ (mix << SHL_B);
   assign s1_n = rotl64(mix, ROT_C);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s0_q <= SEED_INIT[63:0];
         s1_q <= SEED_INIT[127:64];
      end else if (load) begin
         if (seed == 128'd0) begin
            s0_q <= SEED_INIT[63:0];
            s1_q <= SEED_INIT[127:64];
         end else begin
            s0_q <= seed[63:0];
            s1_q <= seed[127:64];
         end
      end else if (step) begin
         s0_q <= s0_n;
         s1_q <= s1_n;
      end
   end

   AST_STATE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (s0_q | s1_q) != 64'd0);                                                   // R7
   AST_PRNG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable({s1_q, s0_q}));                                // R6
endmodule

// File: rtl/fp16sr_core.sv
module fp16sr_core #(
   parameter bit KEEP_PAYLOAD = 1'b1
) (
   input  logic [31:0] in_word,
   input  logic        stoch,
   input  logic [63:0] rnd,
   output logic [15:0] res
);
   import fp16sr_pkg::*;

   localparam int SHR_MAX = 50;

   logic              sgn;
   logic [7:0]        ex;
   logic [22:0]       fr;
   logic [23:0]       sig;
   logic signed [9:0] e_unb, e_off, under;
   logic              is_norm, is_big;
   logic [5:0]        shr;
   logic [74:0]       aligned;
   logic [10:0]       kept;
   logic [63:0]       tail;
   logic              up_rne, up_sr, up;
   logic [15:0]       mag_b, mag_r;
   logic [15:0]       nan_word;

   assign sgn = in_word[31];
   assign ex  = in_word[30:23];
   assign fr  = in_word[22:0];

   if (KEEP_PAYLOAD) begin : g_nan_payload
      assign nan_word = {sgn, HALF_EXP_MAX, 1'b1, fr[22:14]};
   end else begin : g_nan_canon
      assign nan_word = {sgn, HALF_EXP_MAX, 1'b1, 9'd0};
   end

   always_comb begin
      sig     = {|ex, fr};
      e_unb   = (ex == 8'd0) ? -10'sd126 : ($signed({2'b00, ex}) - 10'sd127);
      is_norm = (e_unb >= -10'sd14);
      is_big  = (e_unb > 10'sd15);
      e_off   = e_unb + 10'sd14;
      under   = -10'sd14 - e_unb;
      if (is_norm)                  shr = 6'd0;
      else if (under > 10'sd50)     shr = 6'(SHR_MAX);
      else                          shr = 6'(under);
      aligned = {sig, 51'd0} >> shr;
      kept    = aligned[74:64];
      tail    = aligned[63:0];
      up_rne  = tail[63] & ((|tail[62:0]) | kept[0]);
      up_sr   = (rnd < tail);
      up      = stoch ? up_sr : up_rne;
      mag_b   = is_norm ? ((16'(e_off) << 10) + 16'(kept)) : 16'(kept);
      mag_r   = mag_b + 16'(up);
      if (ex == 8'hFF)
         res = (fr != 23'd0) ? nan_word : {sgn, HALF_INF_MAG};
      else if (is_big || mag_r >= 16'h7C00)
         res = {sgn, HALF_INF_MAG};
      else
         res = {sgn, mag_r[14:0]};
   end
endmodule

// File: rtl/fp16_narrow_sr.sv
module fp16_narrow_sr #(
   parameter logic [127:0] SEED_INIT    = fp16sr_pkg::DEFAULT_STATE,
   parameter bit           KEEP_PAYLOAD = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [31:0]  in_data,
   input  logic         in_stoch,
   input  logic         seed_load,
   input  logic [127:0] seed_value,
   output logic         out_valid,
   output logic [15:0]  out_data
);
   logic        accept;
   logic [63:0] rnd;
   logic [15:0] conv;
   logic [15:0] exact_img;

   assign in_ready = ~seed_load;
   assign accept   = in_valid & in_ready;

   fp16sr_xoro #(.SEED_INIT(SEED_INIT)) u_gen (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (accept & in_stoch),
      .load  (seed_load),
      .seed  (seed_value),
      .rnd   (rnd)
   );

   fp16sr_core #(.KEEP_PAYLOAD(KEEP_PAYLOAD)) u_core (
      .in_word (in_data),
      .stoch   (in_stoch),
      .rnd     (rnd),
      .res     (conv)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= 16'h0000;
      end else begin
         out_valid <= accept;
         if (accept) out_data <= conv;
      end
   end

   assign exact_img = {in_data[31], 5'(in_data[30:23] - 8'd112), in_data[22:13]};

   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> out_valid);                                                      // R2
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> (!out_valid && $stable(out_data)));                             // R2
   AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (out_data[15] == $past(in_data[31])));                           // R11
   AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && in_data[30:23] == 8'hFF && in_data[22:0] != 23'd0)
      |=> (out_data[14:10] == 5'h1F && out_data[9]));                             // R9
   AST_NO_FALSE_INF: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && in_data[30:0] <= 31'h477FE000) |=> (out_data[14:10] != 5'h1F));  // R8
   AST_EXACT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && in_data[30:23] >= 8'd113 && in_data[30:23] <= 8'd142 && in_data[12:0] == 13'd0)
      |=> (out_data == $past(exact_img)));                                        // R4
endmodule

// File: tb/fp16_narrow_sr_test.sv
module fp16_narrow_sr_test;
   logic         clk = 1'b0;
   logic         rst_n;
   logic         in_valid;
   logic         in_ready;
   logic [31:0]  in_data;
   logic         in_stoch;
   logic         seed_load;
   logic [127:0] seed_value;
   logic         out_valid;
   logic [15:0]  out_data;

   always #5 clk = ~clk;

   fp16_narrow_sr uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_stoch(in_stoch), .seed_load(seed_load),
      .seed_value(seed_value), .out_valid(out_valid), .out_data(out_data)
   );

   localparam logic [127:0] RESET_STATE = {64'hD1B54A32D192ED03, 64'h9E3779B97F4A7C15};

   int          n_tests = 0;
   int          n_fail  = 0;
   bit          done    = 1'b0;
   logic [63:0] m_s0, m_s1;
   logic        exp_v;
   logic [15:0] exp_d;
   string       exp_req;

   function automatic logic [63:0] rot(input logic [63:0] v, input int k);
      return (v << k) | (v >> (64 - k));
   endfunction

   task automatic model_step();
      logic [63:0] t;
      t    = m_s0 ^ m_s1;
      m_s0 = rot(m_s0, 24) ^ t ^ (t << 16);
      m_s1 = rot(t, 37);
   endtask

   function automatic logic [15:0] ref_conv(input logic [31:0] x, input bit st, input logic [63:0] r);
      int e, sh;
      longint unsigned sig, kept, rem, half, mag;
      bit up;
      if (x[30:23] == 8'hFF)
         return (x[22:0] != 23'd0) ? {x[31], 5'h1F, 1'b1, x[22:14]} : {x[31], 15'h7C00};
      sig = (x[30:23] == 8'd0) ? 64'(x[22:0]) : 64'({1'b1, x[22:0]});
      e   = (x[30:23] == 8'd0) ? -126 : int'(x[30:23]) - 127;
      if (e > 15) return {x[31], 15'h7C00};
      sh = (e >= -14) ? 13 : -1 - e;
      if (sh > 63) sh = 63;
      kept = sig >> sh;
      rem  = sig & ((64'd1 << sh) - 64'd1);
      if (st) up = ((r >> (64 - sh)) < rem);
      else begin
         half = 64'd1 << (sh - 1);
         up = (rem > half) || (rem == half && kept[0]);
      end
      mag = ((e >= -14) ? (64'(e + 14) << 10) : 64'd0) + kept + 64'(up);
      if (mag >= 64'h7C00) mag = 64'h7C00;
      return {x[31], mag[14:0]};
   endfunction

   task automatic compare();
      n_tests++;
      if (out_valid !== exp_v) begin
         n_fail++;
         $display("FAIL %s out_valid actual %b expected %b", exp_req, out_valid, exp_v);
      end
      n_tests++;
      if (out_data !== exp_d) begin
         n_fail++;
         $display("FAIL %s out_data actual %h expected %h", exp_req, out_data, exp_d);
      end
   endtask

   task automatic step(input bit v, input logic [31:0] x, input bit st,
                       input bit ld, input logic [127:0] seed, input string req);
      @(negedge clk);
      compare();
      in_valid = v; in_data = x; in_stoch = st; seed_load = ld; seed_value = seed;
      #1;
      if (ld) begin
         n_tests++;
         if (in_ready !== 1'b0) begin
            n_fail++;
            $display("FAIL R2 in_ready during seed load actual %b expected 0", in_ready);
         end
      end
      if (v && !ld) begin
         exp_d = ref_conv(x, st, m_s0 + m_s1);
         if (st) model_step();
         exp_v = 1'b1;
      end else exp_v = 1'b0;
      if (ld) {m_s1, m_s0} = (seed == 128'd0) ? RESET_STATE : seed;
      exp_req = req;
   endtask

   task automatic cv(input logic [31:0] x, input bit st, input string req);
      step(1'b1, x, st, 1'b0, 128'd0, req);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_stoch = 1'b0;
      seed_load = 1'b0; seed_value = '0;
      {m_s1, m_s0} = RESET_STATE;
      exp_v = 1'b0; exp_d = 16'h0000; exp_req = "R1";
      repeat (3) @(negedge clk);
      compare();                                   // R1 during reset
      rst_n = 1'b1;
      step(1'b0, 32'd0, 1'b0, 1'b0, 128'd0, "R1"); // R1 after release

      cv(32'h3F800000, 1'b0, "R4");   // 1.0
      cv(32'h3F801000, 1'b0, "R3");   // tie, even stays
      cv(32'h3F803000, 1'b0, "R3");   // tie, odd rounds up
      cv(32'h3F801001, 1'b0, "R3");   // above half
      cv(32'hBF800FFF, 1'b0, "R3");   // below half, negative
      cv(32'h477FE000, 1'b0, "R8");   // 65504
      cv(32'h477FF000, 1'b0, "R8");   // 65520 rounds to inf
      cv(32'hC77FEFFF, 1'b0, "R8");   // just under, stays finite
      cv(32'h501502F9, 1'b0, "R8");   // 1e10
      cv(32'hFF800000, 1'b0, "R8");   // -inf
      cv(32'h7FC00001, 1'b0, "R9");
      cv(32'hFF812345, 1'b1, "R9");
      cv(32'h33800000, 1'b0, "R10");  // 2^-24
      cv(32'h33000000, 1'b0, "R10");  // 2^-25 tie to zero
      cv(32'h33400000, 1'b0, "R10");  // 1.5*2^-25
      cv(32'h38000000, 1'b0, "R10");  // 2^-15
      cv(32'h00000001, 1'b0, "R10");  // binary32 subnormal
      cv(32'h80000000, 1'b0, "R11");  // -0
      cv(32'h00000000, 1'b1, "R11");
      cv(32'h3F800000, 1'b1, "R4");   // exact in stochastic mode
      cv(32'h477FE000, 1'b1, "R4");
      for (int i = 0; i < 40; i++) cv(32'h3F801000, 1'b1, "R5");
      for (int i = 0; i < 20; i++) cv(32'h33012345, 1'b1, "R10");
      step(1'b0, 32'd0, 1'b0, 1'b0, 128'd0, "R6");          // idle, no step
      step(1'b0, 32'd0, 1'b0, 1'b0, 128'd0, "R2");
      step(1'b1, 32'h40490FDB, 1'b1, 1'b1, {64'h1, 64'h2}, "R2"); // ignored request
      for (int i = 0; i < 10; i++) cv(32'h3E2AAAAB, 1'b1, "R7");
      step(1'b0, 32'd0, 1'b0, 1'b1, 128'd0, "R7");          // zero seed
      for (int i = 0; i < 10; i++) cv(32'h3E2AAAAB, 1'b1, "R7");
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] rw, x;
         rw = $urandom();
         x  = $urandom();
         if (rw[1]) x[30:23] = 8'(8'd95 + 8'(rw[9:4]));
         cv(x, rw[0], rw[0] ? "R5" : "R3");
         if (rw[15:12] == 4'd0) step(1'b0, 32'd0, 1'b0, 1'b0, 128'd0, "R6");
         if (rw[23:16] == 8'd0) step(1'b0, 32'd0, 1'b0, 1'b1, {$urandom(), $urandom(), $urandom(), $urandom()}, "R7");
      end
      step(1'b0, 32'd0, 1'b0, 1'b0, 128'd0, "R2");
      step(1'b0, 32'd0, 1'b0, 1'b0, 128'd0, "R2");
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule